// File: doc/BRIEF.md
# Serial Configuration Programming Receiver

This block sits on the device side of a two-wire programming link. A host writes a 192-bit configuration image into the device's non-volatile storage through it. The host first holds the clock line high with the data line low for a minimum time. It then raises the data line within a short window, which opens a programming session. After that, the host clocks in twelve 16-bit words on the clock line. Each word is followed at once by its bitwise complement, and both go least significant bit first.

When a pair checks out, the block spends a parameterised write time storing the word. It then drives an acknowledge on the data pin, which lasts until the next clock-line rising edge. For the first word of a session, the whole store is cleared before the word is written. Two guard inputs must stay low for the whole session; if either rises, the session is dropped. Once all twelve words are in, one readback pass may stream the stored image out on the data pin. A complement mismatch locks the block in an error state until reset.

All pin inputs pass through a synchroniser and are sampled with the system clock. Every time threshold is a count of system-clock ticks. The storage is modelled as a 12 x 16 register array.

State names used throughout:
- IDLE: counting the hold time.
- ARMED: waiting for the data line to rise.
- SHIFT: receiving bits.
- WRITE: the write time.
- ACK: the acknowledge.
- DONE: programming finished, readback allowed.
- VERIFY: the readback pass.
- SPENT: readback used.
- ERROR: complement mismatch.

Transitions:
- IDLE to ARMED when the hold time is met.
- ARMED to SHIFT when the data line rises, or back to IDLE when the window expires, the clock line drops or a guard line rises.
- SHIFT to WRITE on a good pair, or to ERROR on a bad one.
- WRITE to ACK when the write time has elapsed.
- ACK to SHIFT on the releasing edge, or to DONE after the twelfth word.
- DONE to VERIFY on the next edge.
- VERIFY to SPENT after the last bit.
- Any session state (ARMED through VERIFY) to IDLE when a guard line rises.

Top module: `cfgprog_rx`

## Requirements
- R1: After reset the data-pin enable `prog_data_oe_o` is 0 and no session is open.
- R2: A session opens only if the clock line has been high for HOLD_TICKS consecutive system clocks with the data line and both guard lines low, and the data line then rises within ENTRY_TICKS clocks. A shorter hold, or a data rise after the window, opens no session, so later words receive no acknowledge.
- R3: If either guard line goes high during a session, the block returns to IDLE, and words sent afterwards receive no acknowledge.
- R4: In SHIFT, each clock-line rising edge samples one data bit. The first 16 bits are the word (bit 0 first), and the next 16 bits are its complement (bit 0 first).
- R5: After the 32nd bit of a matching pair, the block waits WRITE_TICKS clocks. It then drives `prog_data_oe_o`=1 and `prog_data_o`=1 until the next clock-line rising edge, which carries no data bit.
- R6: If the complement is not the bitwise inverse of the word, nothing is written, no acknowledge is given, and the block stays in ERROR with the data pin released until reset.
- R7: The first word of a session clears all twelve stored words to zero before it is written into word 0.
- R8: After the twelfth acknowledge, the next clock-line rising edge starts readback. Each edge presents one stored bit with `prog_data_oe_o`=1: word 0 bit 0 first, the bits of a word in ascending order, then the next word. The edge after bit 191 releases the pin.
- R9: Readback runs only straight after a completed session and only once. Clock-line edges outside DONE and VERIFY never drive the pin, and after SPENT the pin stays released until reset.
- R10: `prog_data_oe_o` is 0 in IDLE, ARMED, SHIFT, WRITE, SPENT and ERROR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_clk_i | input | 1 | Programming clock line (a button pin) |
| prog_data_i | input | 1 | Data pin, input side |
| guard_a_i | input | 1 | First guard button line, must stay low |
| guard_b_i | input | 1 | Second guard button line, must stay low |
| prog_data_o | output | 1 | Data pin, output value |
| prog_data_oe_o | output | 1 | Data pin output enable (1 drives the pin) |

## Verification
The bench builds the block with HOLD_TICKS=20, ENTRY_TICKS=10 and WRITE_TICKS=30, and keeps the 16-bit words and the 12-word depth. These short thresholds make it cheap to test both a hold that is too short and a data rise that comes after the window. They also allow a whole twelve-word session, a 192-bit readback, an abort and a complement error in one short run. The bench measures the acknowledge delay against WRITE_TICKS directly, in system clocks.

// File: rtl/cfgprog_pkg.sv
package cfgprog_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_ARMED,
        S_SHIFT,
        S_WRITE,
        S_ACK,
        S_DONE,
        S_VERIFY,
        S_SPENT,
        S_ERROR
    } prog_state_e;
endpackage

// File: rtl/cfgprog_insync.sv
// Multi-stage input synchroniser with rising-edge detect per lane.
module cfgprog_insync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] rise
);
    logic [STAGES-1:0][W-1:0] pipe;
    logic [W-1:0]             prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
            prev <= '0;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            prev <= pipe[STAGES-1];
        end
    end

    assign dout = pipe[STAGES-1];
    assign rise = pipe[STAGES-1] & ~prev;
endmodule

// File: rtl/cfgprog_ticker.sv
// Saturating tick counter with synchronous clear.
module cfgprog_ticker #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (clr)       cnt <= '0;
        else if (~&cnt)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cfgprog_store.sv
// Word-organised configuration store with bulk clear.
module cfgprog_store #(
    parameter int WORD_W  = 16,
    parameter int N_WORDS = 12,
    localparam int ADDR_W = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [N_WORDS];
    logic              any_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_WORDS; i++) mem[i] <= '0;
        end else if (clr) begin
            for (int i = 0; i < N_WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    always_comb begin
        any_set = 1'b0;
        for (int i = 0; i < N_WORDS; i++) any_set = any_set | (|mem[i]);
    end

    // R7: a bulk clear leaves every word at zero
    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !any_set);
    // R7: clear and word write never collide
    assert_no_clr_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && we));
    // R4: a committed word lands at its address
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/cfgprog_rx.sv
module cfgprog_rx
    import cfgprog_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int N_WORDS     = 12,
    parameter int HOLD_TICKS  = 9000,
    parameter int ENTRY_TICKS = 4000,
    parameter int WRITE_TICKS = 30000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_clk_i,
    input  logic prog_data_i,
    input  logic guard_a_i,
    input  logic guard_b_i,
    output logic prog_data_o,
    output logic prog_data_oe_o
);
    localparam int BITS    = 2 * WORD_W;
    localparam int BCNT_W  = $clog2(BITS);
    localparam int ADDR_W  = $clog2(N_WORDS);
    localparam int WIDX_W  = $clog2(N_WORDS + 1);
    localparam int BIDX_W  = $clog2(WORD_W);
    localparam int MAXT_A  = (HOLD_TICKS > ENTRY_TICKS) ? HOLD_TICKS : ENTRY_TICKS;
    localparam int MAXT    = (MAXT_A > WRITE_TICKS) ? MAXT_A : WRITE_TICKS;
    localparam int TICK_W  = $clog2(MAXT + 1);

    prog_state_e state_q, state_d;

    logic [3:0] sync_out, sync_rise;
    logic       s_clk, s_data, guard, clk_rise;

    cfgprog_insync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({guard_b_i, guard_a_i, prog_data_i, prog_clk_i}),
        .dout (sync_out),
        .rise (sync_rise)
    );

    assign s_clk    = sync_out[0];
    assign s_data   = sync_out[1];
    assign guard    = sync_out[2] | sync_out[3];
    assign clk_rise = sync_rise[0];

    logic              idle_ok, tick_clr;
    logic [TICK_W-1:0] tick_cnt;

    assign idle_ok  = s_clk & ~s_data & ~guard;
    assign tick_clr = (state_d != state_q) || (state_q == S_IDLE && !idle_ok);

    cfgprog_ticker #(.W(TICK_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tick_clr),
        .cnt  (tick_cnt)
    );

    logic [BITS-1:0]   sr, sr_next;
    logic [BCNT_W-1:0] bit_cnt;
    logic [WIDX_W-1:0] word_idx;
    logic [ADDR_W-1:0] rd_word;
    logic [BIDX_W-1:0] rd_bit;
    logic              pair_ok, last_bit, rd_last, in_session;
    logic              store_clr, store_we;
    logic [WORD_W-1:0] rdata;

    assign sr_next  = {s_data, sr[BITS-1:1]};
    assign pair_ok  = (sr_next[BITS-1:WORD_W] == ~sr_next[WORD_W-1:0]);
    assign last_bit = (bit_cnt == BCNT_W'(BITS - 1));
    assign rd_last  = (rd_word == ADDR_W'(N_WORDS - 1)) && (rd_bit == BIDX_W'(WORD_W - 1));
    assign in_session = (state_q == S_ARMED) || (state_q == S_SHIFT) || (state_q == S_WRITE) ||
                        (state_q == S_ACK) || (state_q == S_DONE) || (state_q == S_VERIFY);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (idle_ok && tick_cnt >= TICK_W'(HOLD_TICKS - 1)) state_d = S_ARMED;
            S_ARMED: begin
                if (guard || !s_clk)                            state_d = S_IDLE;
                else if (s_data)                                state_d = S_SHIFT;
                else if (tick_cnt >= TICK_W'(ENTRY_TICKS - 1))  state_d = S_IDLE;
            end
            S_SHIFT: begin
                if (guard)                      state_d = S_IDLE;
                else if (clk_rise && last_bit)  state_d = pair_ok ? S_WRITE : S_ERROR;
            end
            S_WRITE: begin
                if (guard)                                     state_d = S_IDLE;
                else if (tick_cnt >= TICK_W'(WRITE_TICKS - 1)) state_d = S_ACK;
            end
            S_ACK: begin
                if (guard)         state_d = S_IDLE;
                else if (clk_rise) state_d = (word_idx == WIDX_W'(N_WORDS)) ? S_DONE : S_SHIFT;
            end
            S_DONE: begin
                if (guard)         state_d = S_IDLE;
                else if (clk_rise) state_d = S_VERIFY;
            end
            S_VERIFY: begin
                if (guard)                    state_d = S_IDLE;
                else if (clk_rise && rd_last) state_d = S_SPENT;
            end
            S_SPENT:  state_d = S_SPENT;
            S_ERROR:  state_d = S_ERROR;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    assign store_clr = (state_q == S_SHIFT) && (state_d == S_WRITE) && (word_idx == '0);
    assign store_we  = (state_q == S_WRITE) && (state_d == S_ACK);

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr       <= '0;
            bit_cnt  <= '0;
            word_idx <= '0;
            rd_word  <= '0;
            rd_bit   <= '0;
        end else begin
            if (state_q == S_ARMED && state_d == S_SHIFT) word_idx <= '0;
            else if (store_we)                            word_idx <= word_idx + 1'b1;

            if (state_q != S_SHIFT && state_d == S_SHIFT) begin
                bit_cnt <= '0;
            end else if (state_q == S_SHIFT && clk_rise) begin
                sr      <= sr_next;
                bit_cnt <= bit_cnt + 1'b1;
            end

            if (state_q == S_DONE && state_d == S_VERIFY) begin
                rd_word <= '0;
                rd_bit  <= '0;
            end else if (state_q == S_VERIFY && clk_rise) begin
                if (rd_bit == BIDX_W'(WORD_W - 1)) begin
                    rd_bit  <= '0;
                    rd_word <= rd_word + 1'b1;
                end else begin
                    rd_bit <= rd_bit + 1'b1;
                end
            end
        end
    end

    cfgprog_store #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (store_clr),
        .we   (store_we),
        .waddr(word_idx[ADDR_W-1:0]),
        .wdata(sr[WORD_W-1:0]),
        .raddr(rd_word),
        .rdata(rdata)
    );

    // Outputs
    always_comb begin
        prog_data_o    = 1'b0;
        prog_data_oe_o = 1'b0;
        unique case (state_q)
            S_ACK: begin
                prog_data_o    = 1'b1;
                prog_data_oe_o = 1'b1;
            end
            S_VERIFY: begin
                prog_data_o    = rdata[rd_bit];
                prog_data_oe_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R2: arming needs the full hold count from the ticker
    assert_hold_met_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARMED && $past(state_q) == S_IDLE) |-> $past(tick_cnt) >= TICK_W'(HOLD_TICKS - 1));
    // R3: a guard line in a session drops back to idle
    assert_guard_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_session && guard) |=> state_q == S_IDLE);
    // R5: acknowledge only after the full write time
    assert_ack_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(prog_data_oe_o) && state_q == S_ACK) |-> $past(tick_cnt) >= TICK_W'(WRITE_TICKS - 1));
    // R6: error is sticky and silent
    assert_error_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_ERROR |=> (state_q == S_ERROR && !prog_data_oe_o));
    // R9: readback is spent for good
    assert_spent_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_SPENT |=> (state_q == S_SPENT && !prog_data_oe_o));
    // R8: readback is entered only from the completed state
    assert_verify_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == S_VERIFY) |-> $past(state_q) == S_DONE);
endmodule

// File: tb/cfgprog_rx_tb_top.sv
module cfgprog_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD  = 20;
    localparam int ENTRY = 10;
    localparam int WRT   = 30;
    localparam int NW    = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pclk = 1'b0, pdata = 1'b0, ga = 1'b0, gb = 1'b0;
    logic pout, poe;

    int checks = 0;
    int failures = 0;
    bit exp_q[$];
    event sample_ev;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfgprog_rx #(
        .WORD_W(16), .N_WORDS(NW), .HOLD_TICKS(HOLD),
        .ENTRY_TICKS(ENTRY), .WRITE_TICKS(WRT), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .prog_clk_i(pclk), .prog_data_i(pdata),
        .guard_a_i(ga), .guard_b_i(gb), .prog_data_o(pout), .prog_data_oe_o(poe)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string msg, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    // Monitor: compares each readback sample with the scoreboard queue
    always @(sample_ev) begin
        bit e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R8 readback beyond expected image", 1, 0);
        end else begin
            e = exp_q.pop_front();
            check(poe == 1'b1, "R8 readback enable", int'(poe), 1);
            check(pout == e, "R8 R7 readback bit", int'(pout), int'(e));
        end
    end

    task automatic enter_mode();
        pdata = 1'b0;
        pclk  = 1'b1;
        wait_clks(HOLD + 6);
        pdata = 1'b1;
        wait_clks(4);
        pclk = 1'b0;
        wait_clks(4);
    endtask

    task automatic send_pair(input logic [15:0] w, input logic [15:0] c,
                             input bit exp_ack, input bit push);
        logic [31:0] bits;
        int n;
        bits = {c, w};
        if (push) for (int i = 0; i < 16; i++) exp_q.push_back(w[i]);
        for (int i = 0; i < 31; i++) begin
            pdata = bits[i];
            wait_clks(4);
            pclk = 1'b1;
            wait_clks(4);
            pclk = 1'b0;
            if (i == 20) check(poe == 1'b0, "R10 pin released while shifting", int'(poe), 0);
        end
        pdata = bits[31];
        wait_clks(4);
        pclk = 1'b1;
        n = 0;
        while (!poe && n < WRT + 40) begin
            @(negedge clk);
            n++;
            if (n == 4) pclk = 1'b0;
        end
        pclk = 1'b0;
        if (exp_ack) begin
            check(poe == 1'b1, "R5 acknowledge seen", int'(poe), 1);
            check(n >= WRT && n <= WRT + 5, "R5 acknowledge delay", n, WRT);
            check(pout == 1'b1, "R5 acknowledge level", int'(pout), 1);
            wait_clks(4);
            pclk = 1'b1;
            wait_clks(6);
            check(poe == 1'b0, "R5 acknowledge released by edge", int'(poe), 0);
            pclk = 1'b0;
            wait_clks(4);
        end else begin
            check(poe == 1'b0, "R2 R3 R6 no acknowledge", int'(poe), 0);
        end
    endtask

    task automatic clock_watch(input int n, input string msg);
        int seen;
        seen = 0;
        for (int i = 0; i < n; i++) begin
            pclk = 1'b1;
            for (int k = 0; k < 4; k++) begin @(negedge clk); if (poe) seen++; end
            pclk = 1'b0;
            for (int k = 0; k < 4; k++) begin @(negedge clk); if (poe) seen++; end
        end
        check(seen == 0, msg, seen, 0);
    endtask

    function automatic logic [15:0] word_of(input int k);
        return 16'h3A5C + 16'(k) * 16'h1D27;
    endfunction

    initial begin
        wait_clks(4);
        check(poe == 1'b0, "R1 reset enable low", int'(poe), 0);
        rst_n = 1'b1;
        wait_clks(4);
        check(poe == 1'b0, "R1 idle after reset", int'(poe), 0);

        // R2: hold too short
        pclk = 1'b1;
        wait_clks(HOLD / 2);
        pdata = 1'b1;
        wait_clks(4);
        pclk = 1'b0;
        pdata = 1'b0;
        wait_clks(4);
        send_pair(16'h1111, ~16'h1111, 1'b0, 1'b0);

        // R2: data rises after the entry window
        pclk = 1'b1;
        pdata = 1'b0;
        wait_clks(HOLD + ENTRY + 8);
        pdata = 1'b1;
        wait_clks(4);
        pclk = 1'b0;
        pdata = 1'b0;
        wait_clks(4);
        send_pair(16'h2222, ~16'h2222, 1'b0, 1'b0);

        // R9: no readback without a completed session
        clock_watch(20, "R9 readback refused before programming");

        // R3: guard line aborts a session
        enter_mode();
        send_pair(16'hBEEF, ~16'hBEEF, 1'b1, 1'b0);
        ga = 1'b1;
        wait_clks(6);
        ga = 1'b0;
        wait_clks(4);
        send_pair(16'hCAFE, ~16'hCAFE, 1'b0, 1'b0);

        // R4 R5 R7: full session
        enter_mode();
        for (int k = 0; k < NW; k++) send_pair(word_of(k), ~word_of(k), 1'b1, 1'b1);

        // R8: readback via scoreboard
        for (int b = 0; b < 16 * NW; b++) begin
            pclk = 1'b1;
            wait_clks(6);
            -> sample_ev;
            wait_clks(1);
            pclk = 1'b0;
            wait_clks(4);
        end
        check(exp_q.size() == 0, "R8 all image bits read", exp_q.size(), 0);
        pclk = 1'b1;
        wait_clks(6);
        check(poe == 1'b0, "R8 pin released after bit 191", int'(poe), 0);
        pclk = 1'b0;
        wait_clks(4);
        clock_watch(20, "R9 second readback refused");

        // R6: complement mismatch
        rst_n = 1'b0;
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(3);
        check(poe == 1'b0, "R1 enable low after second reset", int'(poe), 0);
        enter_mode();
        send_pair(16'h5A5A, ~16'h5A5A ^ 16'h0100, 1'b0, 1'b0);
        send_pair(16'h0F0F, ~16'h0F0F, 1'b0, 1'b0);
        clock_watch(20, "R6 error state stays silent");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule